// File: doc/BRIEF.md
# Strobe-Timed DDR Read Capture

This block recovers read data that a memory device sends as a double-data-rate stream with a strobe that travels alongside it. The strobe and the data change at the same moment. The strobe therefore has to be delayed before it can act as a sampling reference. The block runs that delay through a tap line clocked at a fine time step. It samples every data line on each rising and each falling transition of the delayed strobe. Each line's samples are packed into a 4-beat group, and each completed group is handed through a second register stage. That stage is the point where parallel data leaves the capture logic and enters the system side.

One delayed strobe serves all data lines of the byte group. The tap count is chosen by the system from 0 to 63. It is applied only while the read path is quiet, so a burst in flight keeps a consistent sampling point. Short bursts that leave fewer than four beats are cleaned up once the strobe has been quiet for long enough.

Top module: `ddr_rd_capture`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, rd_valid is 0 and rd_word is all zeros.
- R2: Bit 4*i+k of rd_word holds beat k of a group on dq[i]. Beats 0 and 2 are taken on rising delayed-strobe transitions and beats 1 and 3 on falling ones. A burst starts with a rising strobe after a low preamble.
- R3: Each four consecutive strobe transitions of a burst give exactly one rd_valid pulse, so a burst of N beats (N a multiple of 4) gives N/4 pulses.
- R4: Each beat is sampled when the strobe, delayed by the tap count in clock cycles, changes. Every tap from 0 to 63 recovers the sent words, provided each beat is held for UI_TAPS cycles (at least 64).
- R5: When the fourth transition of a group is first sampled at rising clock edge n, rd_valid is high during the cycle that follows edge n+tap+2.
- R6: rd_valid is high for a single cycle at a time. rd_word changes only together with a pulse and keeps its value between pulses.
- R7: tap_sel is taken only while the path is idle. Idle means no transition on the raw or the delayed strobe for 2*UI_TAPS cycles. A tap_sel change made during a burst applies to the next burst.
- R8: When the path turns idle, leftover beats (fewer than four) are dropped without a pulse, and the next burst begins again at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tap-resolution sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dq | input | DQ_W | Read data lines from the memory |
| dqs | input | 1 | Read strobe, edge-aligned with dq, low when idle |
| tap_sel | input | TAP_W | Requested strobe delay in clock cycles |
| rd_word | output | DQ_W*4 | Four beats per data line, oldest beat in the lowest bit |
| rd_valid | output | 1 | One-cycle pulse marking a new rd_word |

## Verification
The bench sweeps every tap from 0 to 63 and checks both the recovered word and the exact cycle of its pulse.

- **Tap 0:** the first strobe transition arrives while the path is still flagged idle. A design that gave the idle flush priority over that edge would lose beat 0 and shift every later word.
- **Tap 63:** the sample lands at the far end of the data eye. A delay line that was off by one would pick up the next beat.
- **Tap change during a burst:** a design that applied it at once would move that burst's pulse timing.
- **Short bursts:** a design that kept the leftover beats of a six- or two-beat burst would build a scrambled first word in the burst that follows.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;
    // beats gathered per data line before a word is released
    localparam int unsigned BEATS = 4;
    typedef logic [1:0] beat_t;
    localparam beat_t LAST_BEAT = 2'd3;
endpackage

// File: rtl/ddr_rdcap_dly_line.sv
// Strobe input register followed by a tap line; one tap equals one clock.
module ddr_rdcap_dly_line #(
    parameter int unsigned TAPS  = 64,
    parameter int unsigned TAP_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_pin,
    input  logic [TAP_W-1:0] tap,
    output logic             strobe_dly,
    output logic             raw_edge
);
    typedef struct packed {
        logic [TAPS-1:0] line;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.line = {st_q.line[TAPS-2:0], strobe_pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // line[0] is the registered pin, line[k] is that value k cycles later
    assign strobe_dly = st_q.line[tap];
    assign raw_edge   = st_q.line[0] ^ st_q.line[1];
endmodule

// File: rtl/ddr_rdcap_capture.sv
// Strobe-edge sampling stage: one delayed strobe times every data line.
module ddr_rdcap_capture
    import ddr_rdcap_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       dq_s,
    input  logic                   strobe_dly,
    input  logic                   flush,
    output logic [LANES*BEATS-1:0] grp_word,
    output logic                   grp_ready,
    output logic                   dly_edge,
    output beat_t                  beat_cnt
);
    localparam int unsigned WW = LANES * BEATS;

    typedef struct packed {
        logic          prev;
        beat_t         beat;
        logic [WW-1:0] gather;
        logic [WW-1:0] word;
        logic          ready;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = strobe_dly;
        st_d.ready = 1'b0;
        dly_edge   = strobe_dly ^ st_q.prev;
        // an edge wins over the flush so beat 0 survives at tap 0
        if (dly_edge) begin
            for (int l = 0; l < LANES; l++) begin
                st_d.gather[l*BEATS + int'(st_q.beat)] = dq_s[l];
            end
            if (st_q.beat == LAST_BEAT) begin
                st_d.word  = st_d.gather;
                st_d.ready = 1'b1;
                st_d.beat  = '0;
            end else begin
                st_d.beat = st_q.beat + 2'd1;
            end
        end else if (flush) begin
            st_d.beat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_word  = st_q.word;
    assign grp_ready = st_q.ready;
    assign beat_cnt  = st_q.beat;
endmodule

// File: rtl/ddr_rdcap_retime.sv
// Hand-off stage: publishes a completed group to the system side.
module ddr_rdcap_retime #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] grp_word,
    input  logic         grp_ready,
    output logic [W-1:0] rd_word,
    output logic         rd_valid
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         valid;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = grp_ready;
        if (grp_ready) st_d.word = grp_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word  = st_q.word;
    assign rd_valid = st_q.valid;
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture
    import ddr_rdcap_pkg::*;
#(
    parameter int unsigned DQ_W    = 8,
    parameter int unsigned TAPS    = 64,
    parameter int unsigned UI_TAPS = 64,
    parameter int unsigned TAP_W   = $clog2(TAPS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DQ_W-1:0]       dq,
    input  logic                  dqs,
    input  logic [TAP_W-1:0]      tap_sel,
    output logic [DQ_W*BEATS-1:0] rd_word,
    output logic                  rd_valid
);
    localparam int unsigned IDLE_CYC = 2 * UI_TAPS;
    localparam int unsigned QW       = $clog2(IDLE_CYC + 1);
    localparam int unsigned WW       = DQ_W * BEATS;

    typedef struct packed {
        logic [DQ_W-1:0]  dq_r;
        logic [TAP_W-1:0] tap;
        logic [QW-1:0]    quiet;
    } st_t;

    st_t st_d, st_q;

    logic             idle;
    logic             raw_edge;
    logic             dly_edge;
    logic             strobe_dly;
    logic             grp_ready;
    logic [WW-1:0]    grp_word;
    beat_t            beat_cnt;
    logic [TAP_W-1:0] cur_tap;

    assign idle    = (st_q.quiet == QW'(IDLE_CYC));
    assign cur_tap = st_q.tap;

    always_comb begin
        st_d      = st_q;
        st_d.dq_r = dq;
        if (raw_edge || dly_edge) st_d.quiet = '0;
        else if (!idle)           st_d.quiet = st_q.quiet + 1'b1;
        if (idle) st_d.tap = tap_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dq_r: '0, tap: '0, quiet: QW'(IDLE_CYC)};
        else        st_q <= st_d;
    end

    ddr_rdcap_dly_line #(.TAPS(TAPS), .TAP_W(TAP_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_pin(dqs),
        .tap       (cur_tap),
        .strobe_dly(strobe_dly),
        .raw_edge  (raw_edge)
    );

    ddr_rdcap_capture #(.LANES(DQ_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .dq_s      (st_q.dq_r),
        .strobe_dly(strobe_dly),
        .flush     (idle),
        .grp_word  (grp_word),
        .grp_ready (grp_ready),
        .dly_edge  (dly_edge),
        .beat_cnt  (beat_cnt)
    );

    ddr_rdcap_retime #(.W(WW)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .grp_word (grp_word),
        .grp_ready(grp_ready),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/ddr_rd_capture_chk.sv
module ddr_rd_capture_chk #(
    parameter int unsigned W     = 32,
    parameter int unsigned TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic [W-1:0]     rd_word,
    input logic             grp_ready,
    input logic             idle,
    input logic             dly_edge,
    input logic [TAP_W-1:0] cur_tap,
    input logic [1:0]       beat_cnt
);
    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_word));

    // R3
    pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(grp_ready));

    // R7
    tap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_tap) |-> $past(idle));

    // R8
    residue_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !dly_edge) |=> (beat_cnt == 2'd0));
endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.W(DQ_W*4), .TAP_W(TAP_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .grp_ready(grp_ready),
    .idle     (idle),
    .dly_edge (dly_edge),
    .cur_tap  (cur_tap),
    .beat_cnt (beat_cnt)
);

// File: tb/test_ddr_rd_capture.sv
module test_ddr_rd_capture;
    localparam int DQ_W     = 8;
    localparam int TAPS     = 64;
    localparam int UI       = 64;
    localparam int TW       = 6;
    localparam int WW       = DQ_W * 4;
    localparam int SETTLE   = 3 * UI + 40;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic [DQ_W-1:0] dq;
    logic            dqs;
    logic [TW-1:0]   tap_sel;
    logic [WW-1:0]   rd_word;
    logic            rd_valid;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic [WW-1:0] exp_w[$];
    int            exp_c[$];
    logic [WW-1:0] last_word = '0;
    logic          prev_valid = 1'b0;

    ddr_rd_capture #(.DQ_W(DQ_W), .TAPS(TAPS), .UI_TAPS(UI)) i_ddr_rd_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .dq      (dq),
        .dqs     (dqs),
        .tap_sel (tap_sel),
        .rd_word (rd_word),
        .rd_valid(rd_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DQ_W-1:0] pat(input int s, input int k);
        int v;
        v = (s * 29 + k * 71 + 13) ^ (k * 8) ^ (s / 4);
        return DQ_W'(v);
    endfunction

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        logic [WW-1:0] w;
        int            c;
        if (rst_n && !done) begin
            if (prev_valid)
                chk(!rd_valid && rd_word == last_word, "R6", "pulse width / word hold",
                    {31'b0, rd_valid, rd_word}, {32'b0, last_word});
            if (rd_valid) begin
                pulses++;
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R3", "unexpected valid pulse", 64'(rd_word), 64'd0);
                end else begin
                    w = exp_w.pop_front();
                    c = exp_c.pop_front();
                    chk(rd_word == w, "R2 R4", "recovered word", 64'(rd_word), 64'(w));
                    chk(cyc == c, "R5", "valid cycle", 64'(cyc), 64'(c));
                end
                last_word = rd_word;
            end
            prev_valid = rd_valid;
        end
    end

    task automatic burst(input int nb, input int seed, input int tap_eff,
                         input int chg_beat, input logic [TW-1:0] chg_val);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            dq  = pat(seed, k);
            dqs = (k % 2 == 0);
            if (k == chg_beat) tap_sel = chg_val;
            if (k % 4 == 3) begin
                logic [WW-1:0] w;
                w = '0;
                for (int j = 0; j < 4; j++) begin
                    logic [DQ_W-1:0] b;
                    b = pat(seed, k - 3 + j);
                    for (int l = 0; l < DQ_W; l++) w[l*4 + j] = b[l];
                end
                exp_w.push_back(w);
                exp_c.push_back(cyc + tap_eff + 3);
            end
            repeat (UI - 1) @(negedge clk);
        end
        @(negedge clk);
        dq = '0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic run(input int nb, input int seed, input int tap,
                       input int chg_beat, input logic [TW-1:0] chg_val, input string req);
        int p0;
        p0 = pulses;
        tap_sel = TW'(tap);
        repeat (3) @(negedge clk);
        burst(nb, seed, tap, chg_beat, chg_val);
        chk(pulses - p0 == nb / 4, req, "valid pulses per burst",
            64'(pulses - p0), 64'(nb / 4));
    endtask

    initial begin
        int f0;
        rst_n   = 1'b0;
        dq      = '0;
        dqs     = 1'b0;
        tap_sel = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "valid after reset", 64'(rd_valid), 64'd0);
        chk(rd_word == '0, "R1", "word after reset", 64'(rd_word), 64'd0);

        // R4 R5: every tap setting with a full 8-beat burst
        for (int t = 0; t < TAPS; t++) run(8, t + 1, t, -1, '0, "R3");

        // R3: longer burst, four words
        run(16, 200, 17, -1, '0, "R3");

        // R7: tap_sel moved during a burst only affects the next one
        f0 = fails;
        run(8, 300, 9, 2, TW'(50), "R7");
        run(8, 301, 50, -1, '0, "R7");
        chk(fails == f0, "R7", "failures across tap change", 64'(fails), 64'(f0));

        // R8: short bursts leave no residue
        run(6, 400, 50, -1, '0, "R8");
        run(2, 401, 50, -1, '0, "R8");
        run(8, 402, 33, -1, '0, "R8");

        chk(exp_w.size() == 0, "R3", "words never delivered", 64'(exp_w.size()), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule